// File: doc/BRIEF.md
# Multi-Channel Gamma Correction Table

This block holds one gamma correction memory that several display channels share. Each channel owns a fixed region of three 256-entry tables of 8-bit values. The red table comes first in the region, then green, then blue. The host fills the memory through a pointer word and a data word. The pointer word carries an address and a step flag. When the flag is set, each data write stores one entry and moves the pointer forward, so a whole region can be streamed in red, then green, then blue order.

On the pixel side, a channel number and three 8-bit component values go in. One cycle later, the three corrected values come out, read in parallel from that channel's three tables. If correction is switched off for the channel, the inputs are passed through unchanged instead.

The table memory is treated as powered off whenever every channel has correction switched off. In that state its contents are lost and must be loaded again. After reset the tables hold the identity curve.

Top module: `gamma_lut_multi`

## Requirements
- R1: After reset, every table entry holds its own index (identity curve). The pointer is 0, the step flag is clear, `out_vld` is 0 and the three outputs are 0.
- R2: Flat address A maps to channel `A / 768`, component `(A / 256) % 3` and index `A % 256`. Component 0 is red, 1 is green and 2 is blue.
- R3: The pointer word carries the address in bits [11:0] and the step flag in bit 12. A pointer write whose address is 2304 or more is ignored: neither the pointer nor the flag changes.
- R4: With the step flag set, a data write stores at the pointer and then advances the pointer by one. From address 2303 the pointer wraps to 0.
- R5: With the step flag clear, a data write stores at the pointer and the pointer stays where it is.
- R6: The stored entry is bits [15:8] of the 16-bit data word.
- R7: A pixel presented with `pix_vld` high gives `out_vld` high on the next cycle. The three outputs are then the red, green and blue entries of channel `pix_ch`, indexed by `pix_r`, `pix_g` and `pix_b`. Outputs hold their value while `pix_vld` is low.
- R8: If `gamma_en[pix_ch]` is 0, or if `pix_ch` is 3 or more, the outputs equal the inputs one cycle later.
- R9: On any clock edge where `gamma_en` is all zero, every entry is cleared to 0, and a data write in that cycle is lost. Entries stay 0 until they are written again.
- R10: If a pointer write and a data write happen in the same cycle, the data is stored at the old pointer. The pointer then takes the new address without stepping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gamma_en | input | 3 | Per-channel correction enable |
| host_addr_we | input | 1 | Pointer word write strobe |
| host_addr_word | input | 13 | Step flag in bit 12, address in bits [11:0] |
| host_data_we | input | 1 | Data word write strobe |
| host_data_word | input | 16 | Host curve value; bits [15:8] are stored |
| pix_vld | input | 1 | Pixel input valid |
| pix_ch | input | 2 | Channel number of the pixel |
| pix_r | input | 8 | Red input |
| pix_g | input | 8 | Green input |
| pix_b | input | 8 | Blue input |
| out_vld | output | 1 | Output valid, one cycle after `pix_vld` |
| out_r | output | 8 | Corrected red |
| out_g | output | 8 | Corrected green |
| out_b | output | 8 | Corrected blue |

## Verification
The assertions check pointer movement on every cycle:
- the step by one and the wrap at the end of the memory;
- the pointer holding still when the step flag is clear;
- out-of-range pointer writes being dropped.

They also check the one-cycle valid timing and the pass-through of uncorrected channels.

Only the bench scenarios can show what is actually stored where:
- region and component placement;
- use of the upper byte of the data word;
- the identity contents after reset;
- the clearing on power-down;
- the ordering when pointer and data writes collide.

The bench shows these by writing entries and reading them back through the pixel path.

// File: rtl/gamma_lut_pkg.sv
// Shared types for the multi-channel gamma table.
// Assumes three colour components stored in red, green, blue order.
package gamma_lut_pkg;
    localparam int NCOMP = 3;

    typedef enum logic [1:0] {
        COMP_RED = 2'd0,
        COMP_GRN = 2'd1,
        COMP_BLU = 2'd2
    } comp_e;
endpackage

// File: rtl/gamma_addr_ptr.sv
// Host write pointer for the gamma memory.
// Decodes a flat address into {channel, component, index}.
// Optionally steps the pointer after each data write.
// Assumes the pointer word holds the step flag just above the address bits.
module gamma_addr_ptr
    import gamma_lut_pkg::*;
#(
    parameter int NUM_CH  = 3,
    parameter int ENTRIES = 256,
    localparam int TOTAL  = NUM_CH * NCOMP * ENTRIES,
    localparam int AW     = $clog2(TOTAL),
    localparam int CHW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int IW     = $clog2(ENTRIES)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           addr_we,
    input  logic [AW:0]    addr_word,
    input  logic           data_we,
    output logic [CHW-1:0] ptr_ch,
    output comp_e          ptr_comp,
    output logic [IW-1:0]  ptr_idx,
    output logic           step_en
);
    localparam int REGION = NCOMP * ENTRIES;

    logic [AW-1:0]  addr_val;
    logic           in_range;
    logic [AW-1:0]  rem;
    logic [CHW-1:0] dec_ch;
    comp_e          dec_comp;
    logic [IW-1:0]  dec_idx;

    // Decode the incoming flat address into its three fields.
    always_comb begin
        addr_val = addr_word[AW-1:0];
        in_range = {1'b0, addr_val} < (AW+1)'(TOTAL);
        dec_ch   = CHW'(addr_val / AW'(REGION));
        rem      = addr_val % AW'(REGION);
        dec_comp = comp_e'(2'(rem / AW'(ENTRIES)));
        dec_idx  = IW'(rem % AW'(ENTRIES));
    end

    // Pointer register: load on an in-range pointer write, otherwise step on data writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_ch   <= '0;
            ptr_comp <= COMP_RED;
            ptr_idx  <= '0;
            step_en  <= 1'b0;
        end else if (addr_we) begin
            if (in_range) begin
                ptr_ch   <= dec_ch;
                ptr_comp <= dec_comp;
                ptr_idx  <= dec_idx;
                step_en  <= addr_word[AW];
            end
        end else if (data_we && step_en) begin
            if (ptr_idx == IW'(ENTRIES - 1)) begin
                ptr_idx <= '0;
                if (ptr_comp == COMP_BLU) begin
                    ptr_comp <= COMP_RED;
                    ptr_ch   <= (ptr_ch == CHW'(NUM_CH - 1)) ? '0 : ptr_ch + 1'b1;
                end else begin
                    ptr_comp <= comp_e'(ptr_comp + 2'd1);
                end
            end else begin
                ptr_idx <= ptr_idx + 1'b1;
            end
        end
    end

    // Flat view of the pointer, used by the checks only.
    logic [AW-1:0] flat;
    assign flat = AW'(ptr_ch) * AW'(REGION) + AW'(ptr_comp) * AW'(ENTRIES) + AW'(ptr_idx);

    // R4
    step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && !addr_we && step_en) |=>
            (flat == (($past(flat) == AW'(TOTAL - 1)) ? '0 : $past(flat) + 1'b1)));

    // R5
    hold_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && !addr_we && !step_en) |=> $stable(flat));

    // R3
    oob_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_we && !in_range) |=> ($stable(flat) && $stable(step_en)));

    // R2
    field_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_comp != 2'd3) && ({1'b0, ptr_ch} < (CHW+1)'(NUM_CH)));
endmodule

// File: rtl/gamma_bank.sv
// One colour component table for all channels.
// Holds NUM_CH x ENTRIES values with one write port and one synchronous read port.
// Loads the identity curve on reset and is wiped to zero by clr (power-down).
// Assumes clr has priority over writes.
module gamma_bank #(
    parameter int NUM_CH  = 3,
    parameter int ENTRIES = 256,
    parameter int DW      = 8,
    localparam int CHW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int IW     = $clog2(ENTRIES)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           wr_en,
    input  logic [CHW-1:0] wr_ch,
    input  logic [IW-1:0]  wr_idx,
    input  logic [DW-1:0]  wr_data,
    input  logic           rd_en,
    input  logic [CHW-1:0] rd_ch,
    input  logic [IW-1:0]  rd_idx,
    output logic [DW-1:0]  rd_data
);
    localparam int DEPTH = NUM_CH * ENTRIES;
    localparam int MW    = $clog2(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [MW-1:0] wr_a;
    logic [MW-1:0] rd_a;

    assign wr_a = MW'(wr_ch) * MW'(ENTRIES) + MW'(wr_idx);
    assign rd_a = MW'(rd_ch) * MW'(ENTRIES) + MW'(rd_idx);

    // Storage: identity on reset, zero on power-down, else host writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= DW'(i % ENTRIES);
        end else if (clr) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_a] <= wr_data;
        end
    end

    // Synchronous read, returning the contents from before the edge.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= mem[rd_a];
    end
endmodule

// File: rtl/gamma_lut_multi.sv
// Multi-channel gamma correction table with a stepping host load port.
// Three component banks are read in parallel for one pixel per cycle, with one cycle latency.
// Assumes the table index width equals the pixel width.
module gamma_lut_multi
    import gamma_lut_pkg::*;
#(
    parameter int NUM_CH  = 3,
    parameter int ENTRIES = 256,
    parameter int DW      = 8,
    parameter int HOST_W  = 16,
    localparam int AW     = $clog2(NUM_CH * NCOMP * ENTRIES),
    localparam int CHW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] gamma_en,
    input  logic              host_addr_we,
    input  logic [AW:0]       host_addr_word,
    input  logic              host_data_we,
    input  logic [HOST_W-1:0] host_data_word,
    input  logic              pix_vld,
    input  logic [CHW-1:0]    pix_ch,
    input  logic [DW-1:0]     pix_r,
    input  logic [DW-1:0]     pix_g,
    input  logic [DW-1:0]     pix_b,
    output logic              out_vld,
    output logic [DW-1:0]     out_r,
    output logic [DW-1:0]     out_g,
    output logic [DW-1:0]     out_b
);
    localparam int IW = $clog2(ENTRIES);

    logic [CHW-1:0] ptr_ch;
    comp_e          ptr_comp;
    logic [IW-1:0]  ptr_idx;
    logic           step_en;
    logic           pwr_down;
    logic           ch_ok;
    logic           corr_hit;
    logic [CHW-1:0] safe_ch;
    logic [DW-1:0]  pix_in  [NCOMP];
    logic [DW-1:0]  rd_val  [NCOMP];
    logic [DW-1:0]  raw_q   [NCOMP];
    logic           byp_q;

    gamma_addr_ptr #(.NUM_CH(NUM_CH), .ENTRIES(ENTRIES)) u_ptr (
        .clk(clk), .rst_n(rst_n),
        .addr_we(host_addr_we), .addr_word(host_addr_word),
        .data_we(host_data_we),
        .ptr_ch(ptr_ch), .ptr_comp(ptr_comp), .ptr_idx(ptr_idx), .step_en(step_en)
    );

    // Channel decode for the pixel path; an unknown channel is always bypassed.
    always_comb begin
        pwr_down  = ~|gamma_en;
        ch_ok     = {1'b0, pix_ch} < (CHW+1)'(NUM_CH);
        corr_hit  = |(gamma_en & (NUM_CH'(1) << pix_ch));
        safe_ch   = ch_ok ? pix_ch : '0;
        pix_in[0] = pix_r;
        pix_in[1] = pix_g;
        pix_in[2] = pix_b;
    end

    for (genvar c = 0; c < NCOMP; c++) begin : g_bank
        gamma_bank #(.NUM_CH(NUM_CH), .ENTRIES(ENTRIES), .DW(DW)) u_bank (
            .clk(clk), .rst_n(rst_n), .clr(pwr_down),
            .wr_en(host_data_we && (ptr_comp == comp_e'(c))),
            .wr_ch(ptr_ch), .wr_idx(ptr_idx),
            .wr_data(host_data_word[HOST_W-1 -: DW]),
            .rd_en(pix_vld), .rd_ch(safe_ch), .rd_idx(IW'(pix_in[c])),
            .rd_data(rd_val[c])
        );

        // Raw input copy for the bypass path.
        always_ff @(posedge clk) begin
            if (!rst_n)       raw_q[c] <= '0;
            else if (pix_vld) raw_q[c] <= pix_in[c];
        end
    end

    // Valid and bypass select, aligned with the bank read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            byp_q   <= 1'b1;
        end else begin
            out_vld <= pix_vld;
            if (pix_vld) byp_q <= !corr_hit;
        end
    end

    // Output select between table value and raw input.
    always_comb begin
        out_r = byp_q ? raw_q[0] : rd_val[0];
        out_g = byp_q ? raw_q[1] : rd_val[1];
        out_b = byp_q ? raw_q[2] : rd_val[2];
    end

    // R7
    vld_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld == $past(pix_vld));

    // R8
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_vld && !corr_hit) |=>
            (out_r == $past(pix_r) && out_g == $past(pix_g) && out_b == $past(pix_b)));

    // R7
    hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_vld |=> ($stable(out_r) && $stable(out_g) && $stable(out_b)));
endmodule

// File: tb/gamma_lut_multi_bench.sv
`timescale 1ns/1ps
module gamma_lut_multi_bench;
    localparam int TOTAL = 2304;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  gamma_en = 3'b111;
    logic        host_addr_we = 1'b0;
    logic [12:0] host_addr_word = '0;
    logic        host_data_we = 1'b0;
    logic [15:0] host_data_word = '0;
    logic        pix_vld = 1'b0;
    logic [1:0]  pix_ch = '0;
    logic [7:0]  pix_r = '0, pix_g = '0, pix_b = '0;
    logic        out_vld;
    logic [7:0]  out_r, out_g, out_b;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [7:0] exp_mem [TOTAL];
    int         m_ptr = 0;
    bit         m_step = 1'b0;

    always #2.5 clk = ~clk;

    gamma_lut_multi u_gamma_lut_multi (
        .clk(clk), .rst_n(rst_n), .gamma_en(gamma_en),
        .host_addr_we(host_addr_we), .host_addr_word(host_addr_word),
        .host_data_we(host_data_we), .host_data_word(host_data_word),
        .pix_vld(pix_vld), .pix_ch(pix_ch), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .out_vld(out_vld), .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    task automatic chk(input string req, input int act, input int exp_v);
        n_chk++;
        if (act != exp_v) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    function automatic int flat(input int ch, input int comp, input int idx);
        return ch * 768 + comp * 256 + idx;
    endfunction

    task automatic set_ptr(input bit st, input int a);
        @(negedge clk);
        host_addr_we = 1'b1;
        host_addr_word = {st, 12'(a)};
        @(negedge clk);
        host_addr_we = 1'b0;
        if (a < TOTAL) begin
            m_ptr = a;
            m_step = st;
        end
    endtask

    task automatic put_data(input logic [15:0] w);
        @(negedge clk);
        host_data_we = 1'b1;
        host_data_word = w;
        @(negedge clk);
        host_data_we = 1'b0;
        if (gamma_en != 0) exp_mem[m_ptr] = w[15:8];
        if (m_step) m_ptr = (m_ptr == TOTAL - 1) ? 0 : m_ptr + 1;
    endtask

    task automatic both_write(input bit st, input int a, input logic [15:0] w);
        @(negedge clk);
        host_addr_we = 1'b1;
        host_addr_word = {st, 12'(a)};
        host_data_we = 1'b1;
        host_data_word = w;
        @(negedge clk);
        host_addr_we = 1'b0;
        host_data_we = 1'b0;
        exp_mem[m_ptr] = w[15:8];
        m_ptr = a;
        m_step = st;
    endtask

    task automatic lookup(input string req, input int ch, input int r, input int g, input int b);
        int er, eg, eb;
        bit corr;
        @(negedge clk);
        pix_vld = 1'b1;
        pix_ch = 2'(ch);
        pix_r = 8'(r);
        pix_g = 8'(g);
        pix_b = 8'(b);
        @(negedge clk);
        pix_vld = 1'b0;
        corr = (ch < 3) && gamma_en[ch];
        er = corr ? int'(exp_mem[flat(ch, 0, r)]) : r;
        eg = corr ? int'(exp_mem[flat(ch, 1, g)]) : g;
        eb = corr ? int'(exp_mem[flat(ch, 2, b)]) : b;
        chk({req, " vld"}, int'(out_vld), 1);
        chk({req, " red"}, int'(out_r), er);
        chk({req, " green"}, int'(out_g), eg);
        chk({req, " blue"}, int'(out_b), eb);
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int seed_dummy;
        for (int i = 0; i < TOTAL; i++) exp_mem[i] = 8'(i % 256);
        seed_dummy = $urandom(32'h5EED_0042);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 out_vld", int'(out_vld), 0);
        chk("R1 out_r", int'(out_r), 0);
        chk("R1 out_g", int'(out_g), 0);
        rst_n = 1'b1;
        lookup("R1 identity", 1, 5, 77, 250);
        lookup("R1 identity", 2, 0, 255, 128);
        // R1/R5: pointer starts at 0 with step clear
        put_data(16'hAB12);
        put_data(16'hCD34);
        lookup("R5 no step", 0, 0, 1, 1);
        chk("R1 R5 entry0", int'(out_r), 8'hCD);
        // R2/R4/R6: stream a region across a component boundary
        set_ptr(1'b1, flat(1, 0, 254));
        put_data(16'h1100);
        put_data(16'h22FF);
        put_data(16'h3355);
        lookup("R2 R4 R6 boundary", 1, 254, 0, 3);
        lookup("R2 R4 R6 boundary", 1, 255, 1, 3);
        // R3: out-of-range pointer write ignored
        set_ptr(1'b1, 10);
        set_ptr(1'b0, 2304);
        put_data(16'h9900);
        put_data(16'h8800);
        lookup("R3 ignored", 0, 10, 10, 10);
        lookup("R3 ignored", 0, 11, 12, 12);
        // R4: wrap from the last address
        set_ptr(1'b1, TOTAL - 1);
        put_data(16'h7700);
        put_data(16'h6600);
        lookup("R4 wrap", 2, 9, 9, 255);
        lookup("R4 wrap", 0, 0, 9, 9);
        // R10: pointer and data write together
        set_ptr(1'b0, flat(2, 1, 40));
        both_write(1'b1, flat(0, 2, 7), 16'h4400);
        put_data(16'h5500);
        lookup("R10 collide", 2, 1, 40, 1);
        lookup("R10 collide", 0, 1, 1, 7);
        lookup("R10 collide", 0, 1, 1, 8);
        // R8: bypass for a disabled channel and an unknown channel
        gamma_en = 3'b101;
        lookup("R8 disabled", 1, 3, 200, 17);
        lookup("R8 unknown ch", 3, 9, 8, 7);
        // R9: power-down wipes the memory
        @(negedge clk);
        gamma_en = 3'b000;
        host_data_we = 1'b1;
        host_data_word = 16'hEE00;
        @(negedge clk);
        host_data_we = 1'b0;
        gamma_en = 3'b111;
        for (int i = 0; i < TOTAL; i++) exp_mem[i] = 8'h00;
        if (m_step) m_ptr = (m_ptr == TOTAL - 1) ? 0 : m_ptr + 1;
        lookup("R9 cleared", 0, 8, 100, 9);
        lookup("R9 cleared", 2, 255, 0, 128);
        // R9: the wiped memory can be reloaded
        set_ptr(1'b1, flat(2, 0, 0));
        for (int i = 0; i < 4; i++) put_data(16'(((i + 1) * 16) << 8));
        lookup("R9 reload", 2, 2, 0, 0);
        // R7: output holds while the pixel valid is low
        @(negedge clk);
        @(negedge clk);
        chk("R7 hold vld", int'(out_vld), 0);
        chk("R7 hold r", int'(out_r), 8'h30);
        // Random mix
        for (int it = 0; it < 60; it++) begin
            int base, len;
            gamma_en = 3'b111;
            base = $urandom_range(0, TOTAL - 1);
            len = $urandom_range(1, 24);
            set_ptr($urandom_range(0, 3) != 0, base);
            for (int k = 0; k < len; k++) put_data(16'($urandom));
            for (int k = 0; k < 6; k++) begin
                int ch;
                gamma_en = 3'($urandom_range(1, 7));
                ch = (k == 0) ? (base / 768) : $urandom_range(0, 3);
                lookup("R7 R2 random", ch,
                       (k == 0) ? base % 256 : $urandom_range(0, 255),
                       $urandom_range(0, 255), $urandom_range(0, 255));
            end
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule